// File: doc/BRIEF.md
# Switch Configuration Register Access Sequencer

This block carries out one 32-bit configuration register access on a remote target that is reached over a two-wire serial bus. It drives a byte-level master controller, which handles all bit timing, clock stretching and arbitration. A request carries the direction, a 5-bit port select, four byte enables and a dword address (bits 11:2), plus the write data for writes. The sequencer packs these into a fixed four-byte command and issues a setup transaction that ends with STOP. A register read then needs a second transaction. That transaction writes a readback code, turns the bus around with a repeated START, and collects four data bytes, which are returned on `rdata`.

A mode input, sampled when the request is accepted, selects between two framings. The block-style framing carries byte-count bytes: one sent by the master in the setup write, and one returned by the target in the readback. The plain framing omits both. A NACK from the target, or a returned count other than four, ends the access early with a STOP and raises `err`.

The byte controller is driven through a level-held command (`bc_valid`, `bc_op`, `bc_wbyte`, `bc_last`). The controller answers each command with a one-cycle `bc_done`, which carries the acknowledge result or the received byte.

Top module: `cfg_access_seq`

## Requirements
- R1: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the access ends. `done` is a one-cycle pulse at the end. A request presented while `busy` is high has no effect on the access in progress.
- R2: The address byte is `{tgt_addr, rw}`, with rw = 0 for every write-direction address and rw = 1 for the address that follows the repeated START.
- R3: The setup transaction is, in order: START, address(write), 0xBA, byte count (block-style framing only), command bytes 1 to 4, STOP. The op codes are 0 for START, 1 for WRITE byte, 2 for READ byte and 3 for STOP. Each command is held unchanged until `bc_done`.
- R4: The command bytes are laid out as follows. Byte 1 is {5'b0, op}, where op is 3 for a register write and 4 for a register read. Byte 2 is {4'b0, port[4:1]}. Byte 3 is {port[0], 1'b0, be[3:0], addr[11:10]}. Byte 4 is addr[9:2].
- R5: A register write sends the four data bytes after command byte 4, least significant byte first. In block-style framing its count byte is 8. No readback transaction follows, and `rdata` reads zero afterwards.
- R6: A register read follows the setup STOP with: START, address(write), 0xBD, START (repeated, with no STOP before it), address(read), count byte (block-style only), four data bytes, STOP. The first data byte received lands in `rdata[7:0]`, and later bytes fill upward.
- R7: In plain framing, no count byte is sent in the setup write and none is read in the readback.
- R8: Every READ command has `bc_last` = 0, except the fourth data byte, which has `bc_last` = 1 (NACK).
- R9: A NACK on any written byte is followed directly by a STOP, with no further bytes. Then `done` pulses with `err` = 1.
- R10: In block-style framing, a received count other than 4 is followed directly by a STOP. Then `done` pulses with `err` = 1.
- R11: A completed access ends with `err` = 0, and a read returns the four received bytes on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_port | input | 5 | Port select |
| req_be | input | 4 | Byte enables, 1 = modify |
| req_addr | input | 10 | Register dword address, bits 11:2 |
| req_wdata | input | 32 | Write data |
| smbus_mode | input | 1 | 1 = framing with count bytes, 0 = plain framing |
| tgt_addr | input | 7 | 7-bit target bus address |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Error status of the last access |
| rdata | output | 32 | Read data of the last access |
| bc_valid | output | 1 | Byte command pending |
| bc_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| bc_wbyte | output | 8 | Byte to transmit for WRITE |
| bc_last | output | 1 | Answer the READ byte with NACK |
| bc_done | input | 1 | Byte command finished |
| bc_nack | input | 1 | Target did not acknowledge the written byte |
| bc_rbyte | input | 8 | Received byte for READ |

## Verification
The bench first sweeps every port select in both framings and both directions, which pins down the bit placement of the port field across command bytes 2 and 3. A walk over all byte-enable values and every single address bit separates the byte-enable field from the address bits. A NACK is then injected at each written-byte position in turn, which shows whether the early STOP comes right after the failing byte. Bad returned counts, plus requests issued while busy, cover the remaining error and ignore paths.

// File: rtl/cfg_access_seq.sv
module cfg_access_seq #(
  parameter logic [7:0] SETUP_CODE = 8'hBA,
  parameter logic [7:0] FETCH_CODE = 8'hBD,
  parameter logic [7:0] RD_COUNT   = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_port,
  input  logic [3:0]  req_be,
  input  logic [11:2] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        smbus_mode,
  input  logic [6:0]  tgt_addr,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        bc_valid,
  output logic [1:0]  bc_op,
  output logic [7:0]  bc_wbyte,
  output logic        bc_last,
  input  logic        bc_done,
  input  logic        bc_nack,
  input  logic [7:0]  bc_rbyte
);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_ST1, S_AD1, S_CODE1, S_CNT1, S_CMD, S_WD, S_SP1,
    S_ST2, S_AD2, S_CODE2, S_RS, S_AD3, S_RCNT, S_RD, S_SP2, S_ABT
  } state_t;

  state_t      st;
  logic [1:0]  idx;
  logic        wr_q, smb_q;
  logic [6:0]  tgt_q;
  logic [31:0] cmd_q, wd_q;

  assign busy     = (st != S_IDLE);
  assign bc_valid = busy;
  assign bc_last  = (st == S_RD) && (idx == 2'd3);

  always_comb begin
    case (st)
      S_ST1, S_ST2, S_RS:   bc_op = OP_START;
      S_RCNT, S_RD:         bc_op = OP_READ;
      S_IDLE, S_SP1, S_SP2, S_ABT: bc_op = OP_STOP;
      default:              bc_op = OP_WRITE;
    endcase
  end

  always_comb begin
    case (st)
      S_AD1, S_AD2: bc_wbyte = {tgt_q, 1'b0};
      S_AD3:        bc_wbyte = {tgt_q, 1'b1};
      S_CODE1:      bc_wbyte = SETUP_CODE;
      S_CODE2:      bc_wbyte = FETCH_CODE;
      S_CNT1:       bc_wbyte = wr_q ? 8'd8 : 8'd4;
      S_CMD:        bc_wbyte = cmd_q[{idx, 3'b000} +: 8];
      S_WD:         bc_wbyte = wd_q[{idx, 3'b000} +: 8];
      default:      bc_wbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; wr_q <= 1'b0; smb_q <= 1'b0; tgt_q <= '0;
      cmd_q <= '0; wd_q <= '0; done <= 1'b0; err <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          st    <= S_ST1;
          idx   <= '0;
          wr_q  <= req_write;
          smb_q <= smbus_mode;
          tgt_q <= tgt_addr;
          wd_q  <= req_wdata;
          err   <= 1'b0;
          rdata <= '0;
          cmd_q <= {req_addr[9:2],
                    req_port[0], 1'b0, req_be, req_addr[11:10],
                    4'b0000, req_port[4:1],
                    5'b00000, (req_write ? 3'd3 : 3'd4)};
        end
      end else if (bc_done) begin
        if (bc_op == OP_WRITE && bc_nack) begin
          st <= S_ABT;
        end else begin
          case (st)
            S_ST1:   st <= S_AD1;
            S_AD1:   st <= S_CODE1;
            S_CODE1: begin st <= smb_q ? S_CNT1 : S_CMD; idx <= '0; end
            S_CNT1:  begin st <= S_CMD; idx <= '0; end
            S_CMD: begin
              idx <= idx + 2'd1;
              if (idx == 2'd3) st <= wr_q ? S_WD : S_SP1;
            end
            S_WD: begin
              idx <= idx + 2'd1;
              if (idx == 2'd3) st <= S_SP1;
            end
            S_SP1: begin
              if (wr_q) begin st <= S_IDLE; done <= 1'b1; end
              else st <= S_ST2;
            end
            S_ST2:   st <= S_AD2;
            S_AD2:   st <= S_CODE2;
            S_CODE2: st <= S_RS;
            S_RS:    st <= S_AD3;
            S_AD3:   begin st <= smb_q ? S_RCNT : S_RD; idx <= '0; end
            S_RCNT:  begin st <= (bc_rbyte == RD_COUNT) ? S_RD : S_ABT; idx <= '0; end
            S_RD: begin
              rdata[{idx, 3'b000} +: 8] <= bc_rbyte;
              idx <= idx + 2'd1;
              if (idx == 2'd3) st <= S_SP2;
            end
            S_SP2:   begin st <= S_IDLE; done <= 1'b1; end
            S_ABT:   begin st <= S_IDLE; done <= 1'b1; err <= 1'b1; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  p_hold_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !bc_done) |=> (bc_valid && $stable(bc_op) && $stable(bc_wbyte)));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bc_op) == OP_STOP && $past(bc_done)));

  p_open_with_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bc_op == OP_START));

  p_err_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_last_is_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bc_last |-> (bc_valid && bc_op == OP_READ));
endmodule

// File: tb/tb_cfg_access_seq.sv
module tb_cfg_access_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, smbus_mode = 1'b0;
  logic [4:0]  req_port = '0;
  logic [3:0]  req_be = '0;
  logic [11:2] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [6:0]  tgt_addr = 7'h38;
  logic        busy, done, err, bc_valid, bc_last;
  logic [31:0] rdata;
  logic [1:0]  bc_op;
  logic [7:0]  bc_wbyte;
  logic        bc_done = 1'b0, bc_nack = 1'b0;
  logic [7:0]  bc_rbyte = '0;

  cfg_access_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .smbus_mode(smbus_mode), .tgt_addr(tgt_addr), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .bc_valid(bc_valid), .bc_op(bc_op), .bc_wbyte(bc_wbyte),
    .bc_last(bc_last), .bc_done(bc_done), .bc_nack(bc_nack), .bc_rbyte(bc_rbyte));

  always #(CLK_PERIOD/2) clk = ~clk;

  // byte controller and target model
  int          nack_at = -1;
  logic [7:0]  rd_bytes [5];
  logic [1:0]  lg_op [64];
  logic [7:0]  lg_b  [64];
  logic        lg_l  [64];
  int          lg_n = 0, wcnt = 0, rcnt = 0, mc = 0;
  logic        mb = 1'b0, pn = 1'b0;
  logic [7:0]  pr = '0;

  always @(posedge clk) begin
    if (!rst_n || !busy) begin wcnt <= 0; rcnt <= 0; end
    if (!rst_n) begin
      mb <= 1'b0; bc_done <= 1'b0;
    end else if (mb) begin
      if (bc_done) begin mb <= 1'b0; bc_done <= 1'b0; end
      else if (mc == 0) begin bc_done <= 1'b1; bc_nack <= pn; bc_rbyte <= pr; end
      else mc <= mc - 1;
    end else if (bc_valid) begin
      lg_op[lg_n % 64] <= bc_op; lg_b[lg_n % 64] <= bc_wbyte; lg_l[lg_n % 64] <= bc_last;
      lg_n <= lg_n + 1;
      mb <= 1'b1; mc <= lg_n % 3;
      pn <= (bc_op == 2'd1) && (wcnt == nack_at);
      pr <= (bc_op == 2'd2 && rcnt < 5) ? rd_bytes[rcnt] : 8'h00;
      if (bc_op == 2'd1) wcnt <= wcnt + 1;
      if (bc_op == 2'd2) rcnt <= rcnt + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [1:0] e_op [64];
  logic [7:0] e_b  [64];
  logic       e_l  [64];
  int         e_n, e_w;
  bit         ab;

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic l);
    if (ab) return;
    e_op[e_n] = op; e_b[e_n] = b; e_l[e_n] = l; e_n++;
    if (op == 2'd1) begin
      if (e_w == nack_at) begin
        e_op[e_n] = 2'd3; e_b[e_n] = 0; e_l[e_n] = 0; e_n++; ab = 1;
      end
      e_w++;
    end
  endtask

  task automatic run(input bit wr, input bit smb, input logic [4:0] port, input logic [3:0] be,
                     input logic [11:0] addr, input logic [31:0] wd, input int nk, input logic [7:0] cnt_ret);
    logic [31:0] rv;
    logic [7:0]  c [4];
    int base, cyc;
    nack_at = nk; e_n = 0; e_w = 0; ab = 0;
    rv = 32'h5A3C_0000 ^ {addr, port, be, 11'h0} ^ {16'h0, wd[15:0]} ^ 32'h0000_1E2D;
    for (int i = 0; i < 5; i++)
      rd_bytes[i] = smb ? ((i == 0) ? cnt_ret : rv[(i-1)*8 +: 8]) : ((i < 4) ? rv[i*8 +: 8] : 8'h00);
    c[0] = wr ? 8'd3 : 8'd4;
    c[1] = 8'(port >> 1);
    c[2] = 8'((port & 5'd1) << 7) | 8'(be << 2) | 8'(addr >> 10);
    c[3] = 8'((addr >> 2) & 12'hFF);
    // R3 R4 R5 R7: setup transaction
    push(0, 0, 0); push(1, {tgt_addr, 1'b0}, 0); push(1, 8'hBA, 0);
    if (smb) push(1, wr ? 8'd8 : 8'd4, 0);
    for (int i = 0; i < 4; i++) push(1, c[i], 0);
    if (wr) for (int i = 0; i < 4; i++) push(1, wd[i*8 +: 8], 0);
    push(3, 0, 0);
    // R6 R8 R10: readback
    if (!wr) begin
      push(0, 0, 0); push(1, {tgt_addr, 1'b0}, 0); push(1, 8'hBD, 0);
      push(0, 0, 0); push(1, {tgt_addr, 1'b1}, 0);
      if (smb) begin
        push(2, 0, 0);
        if (!ab && cnt_ret != 8'd4) begin push(3, 0, 0); ab = 1; end
      end
      for (int i = 0; i < 4; i++) push(2, 0, i == 3);
      push(3, 0, 0);
    end
    base = lg_n;
    @(negedge clk);
    req_write = wr; smbus_mode = smb; req_port = port; req_be = be; req_addr = addr[11:2];
    req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R1 busy after accept", busy, 1);
    repeat (4) @(negedge clk);
    // R1: request while busy must be ignored
    req_write = ~wr; smbus_mode = ~smb; req_port = ~port; req_addr = ~addr[11:2]; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(done == 1, "R1 done pulse", done, 1);
    chk(err == ab, ab ? "R9 R10 err raised" : "R11 err clear", err, ab);
    chk(rdata == ((!wr && !ab) ? rv : 32'h0), wr ? "R5 rdata zero" : "R6 R11 rdata", rdata,
        (!wr && !ab) ? rv : 32'h0);
    chk(lg_n - base == e_n, "R3 R6 R7 R9 command count", lg_n - base, e_n);
    for (int i = 0; i < e_n && i < lg_n - base; i++) begin
      chk(lg_op[(base+i)%64] == e_op[i], "R3 R6 op order", lg_op[(base+i)%64], e_op[i]);
      if (e_op[i] == 2'd1)
        chk(lg_b[(base+i)%64] == e_b[i], "R2 R4 R5 byte value", lg_b[(base+i)%64], e_b[i]);
      if (e_op[i] == 2'd2)
        chk(lg_l[(base+i)%64] == e_l[i], "R8 nack on last", lg_l[(base+i)%64], e_l[i]);
    end
    @(negedge clk);
    chk(done == 0 && busy == 0, "R1 single done pulse", {done, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && bc_valid == 0, "R1 reset state",
        {busy, done, err, bc_valid}, 0);
    chk(rdata == 0, "R11 reset rdata", rdata, 0);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 32; p++)
          run(w[0], s[0], p[4:0], 4'hF ^ 4'(p), 12'((p * 12'h084) & 12'hFFC), 32'h1234_5600 + p, -1, 8'd4);
    for (int b = 0; b < 16; b++) begin
      run(0, 1, 5'd9, b[3:0], 12'h3C0, 0, -1, 8'd4);
      tgt_addr = 7'(7'h11 + b);
      run(1, 0, 5'd22, b[3:0], 12'h0FC, 32'hA1B2_C3D4 ^ b, -1, 8'd4);
    end
    tgt_addr = 7'h38;
    for (int a = 2; a < 12; a++) begin
      run(0, 0, 5'd1, 4'h1, 12'(1 << a), 0, -1, 8'd4);
      run(1, 1, 5'd16, 4'h8, 12'(1 << a), 32'hDEAD_BEEF, -1, 8'd4);
    end
    for (int k = 0; k < 11; k++) run(1, 1, 5'd3, 4'h5, 12'h444, 32'h0BAD_F00D, k, 8'd4);  // R9
    for (int k = 0; k < 10; k++) run(0, 0, 5'd30, 4'hA, 12'h888, 0, k, 8'd4);            // R9
    run(0, 1, 5'd7, 4'h3, 12'h100, 0, -1, 8'd3);   // R10
    run(0, 1, 5'd7, 4'h3, 12'h100, 0, -1, 8'd5);   // R10
    run(0, 1, 5'd7, 4'h3, 12'h100, 0, -1, 8'd0);   // R10
    run(0, 1, 5'd7, 4'h3, 12'h100, 0, -1, 8'd8);   // R10
    run(0, 0, 5'd7, 4'h3, 12'h100, 0, -1, 8'd9);   // R7 count ignored in plain framing
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule